// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block is the receive half of an asynchronous serial port. A free-running sample enable arrives at sixteen times the bit rate. The receiver watches the synchronized serial line for a falling edge and confirms the start bit half a bit later. It then samples each data bit at its centre, and after that an optional parity bit and the first stop bit. Seven or eight data bits can be selected. Parity can be off, even or odd, and the frame can end with one or two stop bits. The sender must use the same format.

Once the first stop bit has been sampled, the character leaves the hidden shift register and enters a holding register that a processor reads. In the same cycle the receiver raises a buffer-full flag, a one-cycle interrupt request and the sticky error flags: overrun, parity and framing. Because the holding register and the shift register are separate, one character can wait in the holding register while the next one shifts in. A read strobe empties the holding register, and a clear strobe resets the error flags.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After synchronous reset, `buf_full`, `rx_irq`, `rx_data` and all three error flags are 0, and the receiver waits for a falling edge on an idle-high line.
- R2: A falling edge is accepted as a start bit only if the line is still low at the 8th sample tick after the tick that saw the edge. A shorter low pulse is discarded and produces no character.
- R3: Data bits are sampled at mid-bit, 16 ticks apart, and assembled least significant bit first. With `cfg_eight`=1 there are 8 data bits. With `cfg_eight`=0 there are 7 data bits and `rx_data[7]` reads 0.
- R4: The character is transferred at the mid-bit sample of the first stop bit, even when `cfg_two_stop`=1. `rx_irq` is a single-cycle pulse in the cycle that `buf_full` becomes 1.
- R5: A one-cycle `rd_strobe` clears `buf_full` on the next clock edge. If a character completes in that same cycle, it is accepted.
- R6: While `buf_full` is 1 and no read occurs, `rx_data` does not change. A character that completes while `buf_full` is 1 sets `err_overrun`, is discarded, and raises no interrupt.
- R7: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity, counted over the data bits plus the parity bit. A mismatch sets `err_parity`.
- R8: A first stop bit that samples as 0 sets `err_framing`.
- R9: The parity and framing flags change only together with a character transfer (the `rx_irq` cycle). All error flags hold until a one-cycle `clr_err` clears them on the next edge.
- R10: With `cfg_two_stop`=1, the receiver ignores the line for one bit time after the first stop bit. A line that goes low during the second stop bit and returns high does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_two_stop | input | 1 | Frame ends with two stop bits |
| rd_strobe | input | 1 | Holding register read strobe |
| clr_err | input | 1 | Clear all error flags |
| rx_data | output | 8 | Holding register contents |
| buf_full | output | 1 | Holding register has an unread character |
| rx_irq | output | 1 | Receive interrupt pulse |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_framing | output | 1 | Sticky framing error flag |

## Verification
The bench builds the receiver with its default parameters: an oversampling factor of 16 and a two-stage input synchronizer. It drives the sample enable once every four clocks, so one bit lasts 64 clocks and a full frame fits in under a thousand cycles. This lets randomized frames sweep every combination of data length, parity mode and stop count. The short bit time also puts the corner cases within a few thousand cycles each: the glitch shorter than half a bit, an overrun, the second stop bit that is ignored, and the exact cycle of the interrupt measured against the edge of the start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_GUARD
    } rx_state_e;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_fmt_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    // Even parity: the data ones plus the parity bit must be even.
    // Odd parity: the same count must be odd.
    function automatic logic parity_bad(input logic [CHAR_W-1:0] d,
                                        input logic pbit,
                                        input logic odd);
        return (^d) ^ pbit ^ odd;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b1;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
            assign dout = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/uart_rx_bitclk.sv
module uart_rx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    output logic at_half,
    output logic at_full
);
    localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CW'(OVS - 1)) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

    assign at_half = tick && (cnt == CW'(HALF - 1));
    assign at_full = tick && (cnt == CW'(OVS - 1));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rx,
    input  rx_fmt_t  fmt,
    input  logic     at_half,
    input  logic     at_full,
    output logic     cnt_clear,
    output logic     done,
    output rx_char_t chr
);
    localparam int IW = $clog2(CHAR_W);

    rx_state_e         state;
    rx_fmt_t           fmt_q;
    logic [CHAR_W-1:0] shreg;
    logic [IW-1:0]     idx;
    logic              pbit;
    logic              prev;
    logic [IW-1:0]     last_idx;

    assign last_idx  = fmt_q.eight ? IW'(CHAR_W - 1) : IW'(CHAR_W - 2);
    assign cnt_clear = (state == RX_IDLE) || ((state == RX_START) && at_half);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            fmt_q <= '0;
            shreg <= '0;
            idx   <= '0;
            pbit  <= 1'b0;
            prev  <= 1'b1;
            done  <= 1'b0;
            chr   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) prev <= rx;
            unique case (state)
                RX_IDLE: begin
                    if (tick && prev && !rx) state <= RX_START;
                end
                RX_START: begin
                    if (at_half) begin
                        if (!rx) begin
                            state <= RX_DATA;
                            fmt_q <= fmt;
                            shreg <= '0;
                            idx   <= '0;
                            pbit  <= 1'b0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_full) begin
                        shreg[idx] <= rx;
                        if (idx == last_idx) state <= fmt_q.par_en ? RX_PAR : RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_full) begin
                        pbit  <= rx;
                        state <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (at_full) begin
                        done        <= 1'b1;
                        chr.data    <= shreg;
                        chr.par_err <= fmt_q.par_en && parity_bad(shreg, pbit, fmt_q.par_odd);
                        chr.frm_err <= !rx;
                        state       <= fmt_q.two_stop ? RX_GUARD : RX_IDLE;
                    end
                end
                RX_GUARD: begin
                    if (at_full) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              rd_strobe,
    input  logic              clr_err,
    output logic [CHAR_W-1:0] data,
    output logic              full,
    output logic              irq,
    output logic              ovr,
    output logic              per,
    output logic              fer
);
    logic [CHAR_W-1:0] data_n;
    logic full_n, irq_n, ovr_n, per_n, fer_n;

    always_comb begin
        data_n = data;
        full_n = full && !rd_strobe;
        irq_n  = 1'b0;
        ovr_n  = ovr && !clr_err;
        per_n  = per && !clr_err;
        fer_n  = fer && !clr_err;
        if (done) begin
            if (full_n) begin
                ovr_n = 1'b1;
            end else begin
                data_n = chr.data;
                full_n = 1'b1;
                irq_n  = 1'b1;
                per_n  = per_n || chr.par_err;
                fer_n  = fer_n || chr.frm_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
            irq  <= 1'b0;
            ovr  <= 1'b0;
            per  <= 1'b0;
            fer  <= 1'b0;
        end else begin
            data <= data_n;
            full <= full_n;
            irq  <= irq_n;
            ovr  <= ovr_n;
            per  <= per_n;
            fer  <= fer_n;
        end
    end
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16x,
    input  logic              rxd,
    input  logic              cfg_eight,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_strobe,
    input  logic              clr_err,
    output logic [CHAR_W-1:0] rx_data,
    output logic              buf_full,
    output logic              rx_irq,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_framing
);
    logic     rx_s;
    logic     at_half, at_full, cnt_clear;
    logic     fr_done;
    rx_char_t fr_chr;
    rx_fmt_t  fmt;

    assign fmt = '{eight: cfg_eight, par_en: cfg_par_en,
                   par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .din(rxd), .dout(rx_s)
    );

    uart_rx_bitclk #(.OVS(OVS)) i_bitclk (
        .clk(clk), .rst(rst), .tick(tick_16x), .clear(cnt_clear),
        .at_half(at_half), .at_full(at_full)
    );

    uart_rx_frame i_frame (
        .clk(clk), .rst(rst), .tick(tick_16x), .rx(rx_s), .fmt(fmt),
        .at_half(at_half), .at_full(at_full), .cnt_clear(cnt_clear),
        .done(fr_done), .chr(fr_chr)
    );

    uart_rx_buffer i_buffer (
        .clk(clk), .rst(rst), .done(fr_done), .chr(fr_chr),
        .rd_strobe(rd_strobe), .clr_err(clr_err),
        .data(rx_data), .full(buf_full), .irq(rx_irq),
        .ovr(err_overrun), .per(err_parity), .fer(err_framing)
    );
endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          rd_strobe,
    input logic          clr_err,
    input logic          fr_done,
    input logic [DW-1:0] rx_data,
    input logic          buf_full,
    input logic          rx_irq,
    input logic          err_overrun,
    input logic          err_parity,
    input logic          err_framing
);
    a_r4_irq_on_fill: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> rx_irq);

    a_r4_irq_full: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> buf_full);

    a_r4_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !fr_done) |=> !buf_full);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !rd_strobe) |=> $stable(rx_data));

    a_r6_overrun: assert property (@(posedge clk) disable iff (rst)
        (buf_full && !rd_strobe && fr_done) |=> (err_overrun && !rx_irq));

    a_r9_par_with_xfer: assert property (@(posedge clk) disable iff (rst)
        $rose(err_parity) |-> rx_irq);

    a_r9_frm_with_xfer: assert property (@(posedge clk) disable iff (rst)
        $rose(err_framing) |-> rx_irq);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !fr_done) |=> (!err_overrun && !err_parity && !err_framing));

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        ((err_overrun || err_parity || err_framing) && !clr_err)
        |=> ((err_overrun || !$past(err_overrun)) && (err_parity || !$past(err_parity))
             && (err_framing || !$past(err_framing))));
endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DW(uart_rx_pkg::CHAR_W)) i_chk (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .clr_err(clr_err),
    .fr_done(fr_done), .rx_data(rx_data), .buf_full(buf_full),
    .rx_irq(rx_irq), .err_overrun(err_overrun), .err_parity(err_parity),
    .err_framing(err_framing)
);

// File: tb/test_uart_rx_dbuf.sv
module test_uart_rx_dbuf;
    localparam int BITCLK = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rxd = 1'b1;
    logic cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic rd_strobe = 1'b0, clr_err = 1'b0;
    logic [7:0] rx_data;
    logic buf_full, rx_irq, err_overrun, err_parity, err_framing;
    logic [1:0] tdiv;
    logic tick_16x;

    int nchk = 0, nbad = 0;
    int cyc = 0, irq_cnt = 0, irq_cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) tdiv <= 2'd0;
        else     tdiv <= tdiv + 2'd1;
    end
    assign tick_16x = (tdiv == 2'd3);

    always @(negedge clk) if (!rst && rx_irq) begin
        irq_cnt = irq_cnt + 1;
        irq_cyc = cyc;
    end

    uart_rx_dbuf i_uart_rx_dbuf (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rxd(rxd),
        .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .rd_strobe(rd_strobe), .clr_err(clr_err),
        .rx_data(rx_data), .buf_full(buf_full), .rx_irq(rx_irq),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data(input logic [7:0] d, input logic eight);
        return eight ? d : {1'b0, d[6:0]};
    endfunction

    int frame_t0;

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit badpar,
                              input bit badstop, input bit lowstop2);
        logic [7:0] m;
        m = exp_data(d, cfg_eight);
        frame_t0 = cyc;
        line_bit(1'b0);
        for (int i = 0; i < (cfg_eight ? 8 : 7); i++) line_bit(m[i]);
        if (cfg_par_en) line_bit((^m) ^ cfg_par_odd ^ badpar);
        line_bit(!badstop);
        if (cfg_two_stop) line_bit(!lowstop2);
        line_bit(1'b1);
    endtask

    task automatic pulse_read();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic pulse_clear();
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
    endtask

    task automatic run_checked(input logic [7:0] d, input bit badpar, input bit badstop);
        int n0, nb, lo;
        n0 = irq_cnt;
        nb = (cfg_eight ? 8 : 7) + (cfg_par_en ? 1 : 0);
        send_frame(d, badpar, badstop, 1'b0);
        lo = frame_t0 + 4 * (8 + 16 * (nb + 1));
        chk(buf_full == 1'b1, "R4 buf_full after frame", buf_full, 1);
        chk(irq_cnt == n0 + 1, "R4 one irq pulse", irq_cnt - n0, 1);
        chk(irq_cyc >= lo && irq_cyc <= lo + 10, "R4 irq at first stop bit", irq_cyc - frame_t0, lo - frame_t0);
        chk(rx_data == exp_data(d, cfg_eight), "R3 data", rx_data, exp_data(d, cfg_eight));
        chk(err_parity == (cfg_par_en && badpar), "R7 parity flag", err_parity, cfg_par_en && badpar);
        chk(err_framing == badstop, "R8 framing flag", err_framing, badstop);
        chk(err_overrun == 1'b0, "R6 no overrun", err_overrun, 0);
        pulse_read();
        chk(buf_full == 1'b0, "R5 read clears full", buf_full, 0);
        pulse_clear();
        chk({err_overrun, err_parity, err_framing} == 3'b000, "R9 clear errors",
            {err_overrun, err_parity, err_framing}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        int seed, n0;
        logic [7:0] a, b;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk({buf_full, rx_irq, err_overrun, err_parity, err_framing} == 5'b0, "R1 flags reset",
            {buf_full, rx_irq, err_overrun, err_parity, err_framing}, 0);
        chk(rx_data == 8'h00, "R1 data reset", rx_data, 0);
        repeat (BITCLK) @(negedge clk);

        // Directed: 8N1, 7-bit with bit7 set, even/odd parity, 2 stop
        run_checked(8'hA5, 0, 0);
        cfg_eight = 1'b0;
        run_checked(8'hFF, 0, 0);        // R3: bit 7 reads 0
        cfg_eight = 1'b1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        run_checked(8'h37, 0, 0);
        run_checked(8'h37, 1, 0);        // R7 even mismatch
        cfg_par_odd = 1'b1;
        run_checked(8'hC1, 1, 0);        // R7 odd mismatch
        cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        run_checked(8'h5A, 0, 0);        // R4 transfer at first of two stops
        cfg_two_stop = 1'b0;
        run_checked(8'h0F, 0, 1);        // R8 framing

        // R2: glitch shorter than half a bit
        n0 = irq_cnt;
        rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (3 * BITCLK) @(negedge clk);
        chk(buf_full == 1'b0 && irq_cnt == n0, "R2 glitch rejected", irq_cnt - n0, 0);

        // R6: overrun keeps first character
        a = 8'h3C; b = 8'hC3;
        n0 = irq_cnt;
        send_frame(a, 0, 0, 0);
        send_frame(b, 0, 0, 0);
        chk(err_overrun == 1'b1, "R6 overrun flagged", err_overrun, 1);
        chk(rx_data == a, "R6 old data kept", rx_data, a);
        chk(irq_cnt == n0 + 1, "R6 no irq on overrun", irq_cnt - n0, 1);
        chk(err_overrun == 1'b1, "R9 overrun sticky", err_overrun, 1);
        pulse_read();
        pulse_clear();
        chk(buf_full == 1'b0 && err_overrun == 1'b0, "R9 overrun cleared", err_overrun, 0);

        // R10: low second stop bit ignored
        cfg_two_stop = 1'b1;
        n0 = irq_cnt;
        send_frame(8'h81, 0, 0, 1);
        chk(rx_data == 8'h81 && irq_cnt == n0 + 1, "R10 first char", rx_data, 8'h81);
        pulse_read();
        repeat (12 * BITCLK) @(negedge clk);
        chk(buf_full == 1'b0 && irq_cnt == n0 + 1, "R10 no spurious start", irq_cnt - n0, 1);
        pulse_clear();

        // Random formats and data
        for (int k = 0; k < 40; k++) begin
            bit bp, bs;
            cfg_eight    = $urandom_range(0, 1);
            cfg_par_en   = $urandom_range(0, 1);
            cfg_par_odd  = $urandom_range(0, 1);
            cfg_two_stop = $urandom_range(0, 1);
            bp = ($urandom_range(0, 3) == 0);
            bs = ($urandom_range(0, 5) == 0);
            run_checked(8'($urandom), bp, bs);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule